// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a 64-word by 36-bit first-in first-out buffer. Its write side and its read side run on separate clocks that need no fixed relation to each other. Pointers cross between the two domains in Gray code. Every status flag leaves a two-flop path in its own clock domain. The write side sees "full" and "almost full". The read side sees "empty" and "almost empty". All four flags are active low.

A single asynchronous active-low reset clears both pointers and sets the flags to a known state. On the rising edge of that reset, a 2-bit select input picks the almost-flag threshold. The port wrappers around the block handle bus-width matching and pad control, and they only need the enable/flag handshake on each side. A write counts when `wr_en` is high and `full_n` is high. A read counts when `rd_en` is high and `empty_n` is high. A read loads the oldest word into a registered `rdata` output.

Top module: `dcfifo_pf`

## Requirements
- R1: While `rst_n` is low, `full_n` is 0, `afull_n` is 1, `empty_n` is 0, `aempty_n` is 0 and `rdata` is 0.
- R2: After `rst_n` rises, `full_n` is still 0 after the first `wclk` rising edge and is 1 after the second.
- R3: The almost-flag threshold is taken from `fsel` on the rising edge of `rst_n`. The encoding is `fsel`=00 for 4 words, 01 for 8, 10 for 12 and 11 for 16.
- R4: After a write edge on an empty FIFO, `empty_n` stays 0 after the first `rclk` rising edge and becomes 1 on the second. The word can be read on the third `rclk` edge.
- R5: A read attempted while `empty_n` is 0 is ignored. `rdata` holds its value, and the next successful read returns the oldest stored word.
- R6: On an `rclk` edge with `rd_en` and `empty_n` both high, `rdata` takes the oldest unread word. Words come out in write order with no loss or duplication.
- R7: Once settled, `aempty_n` is 0 when the stored word count is at most the threshold and 1 when it is above it.
- R8: Once settled, `afull_n` is 0 when the free space (64 minus the count) is at most the threshold and 1 when it is above it.
- R9: `full_n` is 0 once 64 words are stored. A write attempted while `full_n` is 0 is ignored and stores nothing.
- R10: After a read frees a slot in a full FIFO, `full_n` returns to 1 once the read pointer has crossed into the write domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low; its rising edge latches `fsel` |
| fsel | input | 2 | Almost-flag threshold select |
| wr_en | input | 1 | Write request |
| wdata | input | 36 | Write data |
| full_n | output | 1 | Low when full (write clock) |
| afull_n | output | 1 | Low when almost full (write clock) |
| rd_en | input | 1 | Read request |
| rdata | output | 36 | Registered read data |
| empty_n | output | 1 | Low when empty (read clock) |
| aempty_n | output | 1 | Low when almost empty (read clock) |

## Verification
The bench runs four kinds of traffic:
- **Single word into an empty FIFO.** This pins down the two-edge empty latency and separates a one-stage crossing from a three-stage one.
- **Reads held high while empty, followed by a write.** This shows whether an ignored read moved the read pointer.
- **Bursts sized exactly at the threshold and one word past it, under each of the four `fsel` codes.** These separate a wrong select encoding from an off-by-one in the almost-empty comparison.
- **A fill to 64 words with extra writes, then a full drain.** This checks almost-full at free space 5 versus 4, confirms that writes past full are dropped, and confirms that all 64 slots come back out in order.

// File: rtl/dcfifo_pf.sv
module dcfifo_pf #(
  parameter int DW       = 36,
  parameter int AW       = 6,
  parameter int OFS_STEP = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [1:0]    fsel,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          full_n,
  output logic          afull_n,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return (b >> 1) ^ b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] ofs;

  always_ff @(posedge rst_n)
    ofs <= PW'(OFS_STEP) * (PW'(fsel) + PW'(1));

  // write domain
  logic [PW-1:0] wbin, wgray, rq1;
  logic          wready;
  logic          wfire;
  logic [PW-1:0] wbin_nx, wgray_nx, wused_nx, rfull_pat;

  assign wfire     = wr_en & full_n;
  assign wbin_nx   = wbin + PW'(wfire);
  assign wgray_nx  = b2g(wbin_nx);
  assign wused_nx  = wbin_nx - g2b(rq1);
  assign rfull_pat = {~rq1[PW-1:PW-2], rq1[PW-3:0]};

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      rq1     <= '0;
      wready  <= 1'b0;
      full_n  <= 1'b0;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wgray_nx;
      rq1     <= rgray;
      wready  <= 1'b1;
      full_n  <= wready & (wgray_nx != rfull_pat);
      afull_n <= (PW'(DEPTH) - wused_nx) > ofs;
    end
  end

  always_ff @(posedge wclk)
    if (wfire) mem[wbin[AW-1:0]] <= wdata;

  // read domain
  logic [PW-1:0] rbin, rgray, wq1;
  logic          rfire;
  logic [PW-1:0] rbin_nx, rgray_nx, rused_nx;

  assign rfire    = rd_en & empty_n;
  assign rbin_nx  = rbin + PW'(rfire);
  assign rgray_nx = b2g(rbin_nx);
  assign rused_nx = g2b(wq1) - rbin_nx;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wq1      <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
      rdata    <= '0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rgray_nx;
      wq1      <= wgray;
      empty_n  <= (rgray_nx != wq1);
      aempty_n <= rused_nx > ofs;
      if (rfire) rdata <= mem[rbin[AW-1:0]];
    end
  end
endmodule

module dcfifo_pf_chk #(
  parameter int DW = 36
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic          rd_en,
  input logic [DW-1:0] rdata
);
  // R1
  always @(posedge wclk)
    if (!rst_n) begin
      rst_state_chk: assert (!full_n && afull_n && !empty_n && !aempty_n)
        else $error("R1 flags not in reset state");
    end

  // R5
  read_ignored_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_en && !empty_n) |=> $stable(rdata));

  // R7
  empty_implies_ae_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  // R8
  full_implies_af_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $fell(full_n) |-> !afull_n);
endmodule

bind dcfifo_pf dcfifo_pf_chk #(.DW(DW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .rd_en(rd_en), .rdata(rdata)
);

// File: tb/sim_dcfifo_pf.sv
module sim_dcfifo_pf;
  localparam int DW = 36;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b1;
  logic [1:0]    fsel = 2'b00;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          full_n, afull_n, empty_n, aempty_n;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] seed = 36'h0_1234_5678;

  dcfifo_pf u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fsel(fsel),
    .wr_en(wr_en), .wdata(wdata), .full_n(full_n), .afull_n(afull_n),
    .rd_en(rd_en), .rdata(rdata), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  always #10 wclk = ~wclk;
  initial begin
    #7;
    forever #10 rclk = ~rclk;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard compare on every accepted read (R6)
  initial begin
    forever begin
      bit f;
      @(negedge rclk);
      f = rd_en && empty_n;
      @(posedge rclk);
      #2;
      if (f) begin
        if (q.size() == 0) chk(1'b0, "R6 extra read", 64'(rdata), 0);
        else begin
          logic [DW-1:0] e;
          e = q.pop_front();
          chk(rdata == e, "R6 order", 64'(rdata), 64'(e));
        end
      end
    end
  end

  task automatic write_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      seed = {seed[DW-2:0], seed[DW-1] ^ seed[DW-3]} + 36'h9_0001;
      wr_en = 1'b1;
      wdata = seed;
      if (full_n) q.push_back(seed);
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic read1();
    @(posedge rclk); #1 rd_en = 1'b1;
    @(posedge rclk); #1 rd_en = 1'b0;
  endtask

  task automatic drain();
    @(posedge rclk); #1 rd_en = 1'b1;
    for (int i = 0; i < 300 && q.size() != 0; i++) @(posedge rclk);
    #1 rd_en = 1'b0;
    repeat (3) @(posedge rclk);
    #2;
    chk(q.size() == 0, "R6 all drained", 64'(q.size()), 0);
    chk(empty_n == 1'b0, "R6 empty after drain", 64'(empty_n), 0);
  endtask

  task automatic settle();
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    #2;
  endtask

  task automatic do_reset(input logic [1:0] fs);
    fsel = fs;
    rst_n = 1'b0;
    repeat (5) @(posedge wclk);
    @(negedge wclk);
    // R1
    chk(full_n == 1'b0, "R1 full_n", 64'(full_n), 0);
    chk(afull_n == 1'b1, "R1 afull_n", 64'(afull_n), 1);
    chk(empty_n == 1'b0, "R1 empty_n", 64'(empty_n), 0);
    chk(aempty_n == 1'b0, "R1 aempty_n", 64'(aempty_n), 0);
    chk(rdata == '0, "R1 rdata", 64'(rdata), 0);
    rst_n = 1'b1;
    @(posedge wclk); #2;
    chk(full_n == 1'b0, "R2 first edge", 64'(full_n), 0);
    @(posedge wclk); #2;
    chk(full_n == 1'b1, "R2 second edge", 64'(full_n), 1);
    repeat (3) @(posedge rclk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    do_reset(2'b00);

    // R5: reads while empty are ignored
    @(posedge rclk); #1 rd_en = 1'b1;
    repeat (5) @(posedge rclk);
    #1 rd_en = 1'b0;
    #1;
    chk(rdata == '0, "R5 rdata held", 64'(rdata), 0);
    chk(empty_n == 1'b0, "R5 still empty", 64'(empty_n), 0);

    // R4: empty latency after a single write
    @(negedge wclk);
    wr_en = 1'b1;
    wdata = 36'hA_5A5A_0F0F;
    q.push_back(wdata);
    @(posedge wclk);
    #1 wr_en = 1'b0;
    @(posedge rclk); #2;
    chk(empty_n == 1'b0, "R4 first rclk edge", 64'(empty_n), 0);
    @(posedge rclk); #2;
    chk(empty_n == 1'b1, "R4 second rclk edge", 64'(empty_n), 1);
    #1 rd_en = 1'b1;
    @(posedge rclk); #1 rd_en = 1'b0;
    #1;
    chk(rdata == 36'hA_5A5A_0F0F, "R4 R5 word read on third edge", 64'(rdata), 64'h0A_5A5A_0F0F);
    settle();
    chk(empty_n == 1'b0, "R4 empty again", 64'(empty_n), 0);

    // R3 / R7: threshold per select code
    for (int fs = 0; fs < 4; fs++) begin
      int th;
      th = 4 * (fs + 1);
      do_reset(2'(fs));
      write_burst(th);
      settle();
      chk(aempty_n == 1'b0, "R3 R7 at threshold", 64'(aempty_n), 0);
      write_burst(1);
      settle();
      chk(aempty_n == 1'b1, "R3 R7 above threshold", 64'(aempty_n), 1);
      read1();
      settle();
      chk(aempty_n == 1'b0, "R7 back to threshold", 64'(aempty_n), 0);
      drain();
    end

    // R8 / R9 / R10: fill with threshold 4
    do_reset(2'b00);
    write_burst(59);
    settle();
    chk(afull_n == 1'b1, "R8 free 5", 64'(afull_n), 1);
    chk(aempty_n == 1'b1, "R7 many words", 64'(aempty_n), 1);
    write_burst(1);
    settle();
    chk(afull_n == 1'b0, "R8 free 4", 64'(afull_n), 0);
    chk(full_n == 1'b1, "R9 not yet full", 64'(full_n), 1);
    write_burst(4);
    settle();
    chk(full_n == 1'b0, "R9 full at 64", 64'(full_n), 0);
    chk(q.size() == 64, "R9 accepted count", 64'(q.size()), 64);
    write_burst(3);
    settle();
    chk(q.size() == 64, "R9 writes while full dropped", 64'(q.size()), 64);
    read1();
    settle();
    chk(full_n == 1'b1, "R10 full released", 64'(full_n), 1);
    chk(afull_n == 1'b0, "R8 free 1", 64'(afull_n), 0);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule